// File: doc/BRIEF.md
# Inter-processor interrupt register block

A memory-mapped register block through which one agent signals up to eleven peer agents and collects their signals in return. Software writes a word to a trigger register to send one-clock pulses out on selected channels. Inbound request lines from peers latch into a sticky status register, and software clears that register by writing ones. Each channel can be masked. The block raises one combined interrupt output whenever an unmasked status bit is pending.

The eleven channels sit at fixed, sparse bit positions of the 32-bit register word. Every other bit is reserved. The mask cannot be written directly. Software changes it only through two strobe registers, one that unmasks channels and one that masks them, and both of these read as zero. The current status word is also driven out on eleven observation levels, one per channel. A separate read-only register shows the levels of the inbound observation lines.

Top module: `ipi_regblk`

## Requirements
- R1: Channel i (i = 0..10) uses register bit 0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27 respectively (channel bit mask 0x0F0F0301). Writes to any other bit of any register are ignored, and reads of those bits return zero.
- R2: Registers are decoded on word offsets: trigger 0x00, observation 0x04, status 0x10, mask 0x14, unmask strobe 0x18, mask strobe 0x1C. A write to any other offset changes nothing, and a read of any other offset returns zero. Read data is combinational from the current address.
- R3: A write to the trigger register drives `trig_o[i]` high for exactly the one clock cycle following the write, for each channel whose bit was written as one. `trig_o` is zero in every other cycle. The trigger register always reads zero.
- R4: A high `req_i` bit at a channel position sets that status bit on the next clock edge. The bit stays set until a write of one to that bit of the status register clears it on the next edge. Status resets to zero.
- R5: If a request and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `obs_o[i]` equals the status bit of channel i at all times.
- R7: The mask register resets to 0x0F0F0301 (all channels masked). Bus writes to offset 0x14 do not change it.
- R8: Writing a one to a bit of the unmask strobe clears that mask bit on the next edge. Writing a one to a bit of the mask strobe sets it. Both strobe registers read zero.
- R9: `irq_o` is high exactly when some status bit is set while its mask bit is clear, including directly after reset.
- R10: The observation register (0x04) holds the channel bits of `obs_in_i` as sampled on the previous clock edge. It is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Byte address of register access |
| bus_we_i | input | 1 | Write strobe, one write per cycle when high |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| req_i | input | 32 | Inbound request lines, channel positions used |
| obs_in_i | input | 32 | Inbound observation levels, channel positions used |
| trig_o | output | 11 | Outbound trigger pulses, one per channel |
| obs_o | output | 11 | Outbound mirror of status, one per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets a request colliding with a clear of the same bit. A design that lets the clear win silently drops an event. It writes all ones to the trigger register and checks for a pulse of exactly one cycle on every channel. A wrong bit-position map or a level that does not drop shows up as stray or stuck trigger bits. It writes reserved-only data to the mask strobe and all ones directly to the mask. A design that decodes too many bits, or lets the mask be written, then shows a changed mask and a wrong `irq_o`. Unmapped offsets are read and written to catch aliasing in a loose address decode.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int NCH = 11;

  // word indices of registers
  localparam int W_TRIG = 0;
  localparam int W_OBS  = 1;
  localparam int W_STAT = 4;
  localparam int W_MASK = 5;
  localparam int W_EN   = 6;
  localparam int W_DIS  = 7;

  function automatic int chan_pos(input int i);
    case (i)
      0:  return 0;
      1:  return 8;
      2:  return 9;
      3:  return 16;
      4:  return 17;
      5:  return 18;
      6:  return 19;
      7:  return 24;
      8:  return 25;
      9:  return 26;
      default: return 27;
    endcase
  endfunction

  function automatic logic [31:0] chan_mask();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NCH; i++) m[chan_pos(i)] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic trig;
    logic stat;
    logic en;
    logic dis;
  } wr_sel_t;

  typedef enum logic [1:0] {RD_ZERO, RD_OBS, RD_STAT, RD_MASK} rd_src_t;
endpackage

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output wr_sel_t           sel_o,
  output rd_src_t           src_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr_i[ADDR_W-1:2];

  always_comb begin
    sel_o = '0;
    src_o = RD_ZERO;
    if (word == WORD_W'(W_OBS))  src_o = RD_OBS;
    if (word == WORD_W'(W_STAT)) src_o = RD_STAT;
    if (word == WORD_W'(W_MASK)) src_o = RD_MASK;
    if (we_i) begin
      sel_o.trig = (word == WORD_W'(W_TRIG));
      sel_o.stat = (word == WORD_W'(W_STAT));
      sel_o.en   = (word == WORD_W'(W_EN));
      sel_o.dis  = (word == WORD_W'(W_DIS));
    end
  end
endmodule

// File: rtl/ipi_chan_slice.sv
module ipi_chan_slice
  import ipi_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  wr_sel_t sel_i,
  input  logic    wbit_i,
  input  logic    req_i,
  input  logic    obs_in_i,
  output logic    trig_o,
  output logic    stat_o,
  output logic    mask_o,
  output logic    obs_o
);
  logic trig_q, stat_q, mask_q, obs_q;
  logic clr;

  assign clr = sel_i.stat & wbit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      stat_q <= 1'b0;
      mask_q <= 1'b1;
      obs_q  <= 1'b0;
    end else begin
      trig_q <= sel_i.trig & wbit_i;
      stat_q <= (stat_q & ~clr) | req_i;   // set wins over clear
      if (sel_i.en && wbit_i)       mask_q <= 1'b0;
      else if (sel_i.dis && wbit_i) mask_q <= 1'b1;
      obs_q  <= obs_in_i;
    end
  end

  assign trig_o = trig_q;
  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign obs_o  = obs_q;

  assert_trig_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> $past(sel_i.trig && wbit_i));
  assert_trig_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i.trig && wbit_i) |=> !trig_q);
  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !(sel_i.stat && wbit_i)) |=> stat_q);
  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && sel_i.stat && wbit_i) |=> stat_q);
  assert_unmask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i.en && wbit_i) |=> !mask_q);
  assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i.dis && wbit_i) |=> mask_q);
endmodule

// File: rtl/ipi_rd_mux.sv
module ipi_rd_mux
  import ipi_pkg::*;
(
  input  rd_src_t     src_i,
  input  logic [31:0] obs_i,
  input  logic [31:0] stat_i,
  input  logic [31:0] mask_i,
  output logic [31:0] rdata_o
);
  always_comb begin
    unique case (src_i)
      RD_OBS:  rdata_o = obs_i;
      RD_STAT: rdata_o = stat_i;
      RD_MASK: rdata_o = mask_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ipi_regblk.sv
module ipi_regblk
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [31:0]       req_i,
  input  logic [31:0]       obs_in_i,
  output logic [NCH-1:0]    trig_o,
  output logic [NCH-1:0]    obs_o,
  output logic              irq_o
);
  localparam logic [31:0] CMASK = chan_mask();

  wr_sel_t  sel;
  rd_src_t  src;
  logic [NCH-1:0] stat_b, mask_b, obsr_b;
  logic [31:0] stat_v, mask_v, obsr_v;
  logic unused_bits;

  assign unused_bits = ^{req_i & ~CMASK, obs_in_i & ~CMASK, bus_wdata_i & ~CMASK};

  ipi_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(bus_addr_i), .we_i(bus_we_i), .sel_o(sel), .src_o(src)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int P = chan_pos(i);
    ipi_chan_slice u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel),
      .wbit_i  (bus_wdata_i[P]),
      .req_i   (req_i[P]),
      .obs_in_i(obs_in_i[P]),
      .trig_o  (trig_o[i]),
      .stat_o  (stat_b[i]),
      .mask_o  (mask_b[i]),
      .obs_o   (obsr_b[i])
    );
  end

  always_comb begin
    stat_v = '0;
    mask_v = '0;
    obsr_v = '0;
    for (int i = 0; i < NCH; i++) begin
      stat_v[chan_pos(i)] = stat_b[i];
      mask_v[chan_pos(i)] = mask_b[i];
      obsr_v[chan_pos(i)] = obsr_b[i];
    end
  end

  ipi_rd_mux u_rd (
    .src_i(src), .obs_i(obsr_v), .stat_i(stat_v), .mask_i(mask_v),
    .rdata_o(bus_rdata_o)
  );

  assign obs_o = stat_b;
  assign irq_o = |(stat_b & ~mask_b);

  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_b) |-> !irq_o);
  assert_irq_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obs_o == '0) |-> !irq_o);
  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rdata_o & ~CMASK) == '0);
endmodule

// File: tb/sim_ipi_regblk.sv
`timescale 1ns/1ps
module sim_ipi_regblk;
  localparam logic [31:0] CM = 32'h0F0F0301;
  localparam int POS [11] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0, rdata, req = '0, obs_in = '0;
  logic [10:0] trig, obs_out;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_stat, m_mask, m_obs;
  logic [10:0] m_trig;

  always #4 clk = ~clk;

  ipi_regblk u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .req_i(req), .obs_in_i(obs_in),
    .trig_o(trig), .obs_o(obs_out), .irq_o(irq)
  );

  function automatic logic [10:0] gather(input logic [31:0] v);
    logic [10:0] g;
    for (int i = 0; i < 11; i++) g[i] = v[POS[i]];
    return g;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h04:   return m_obs;
      8'h10:   return m_stat;
      8'h14:   return m_mask;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h00:        return "R3";
      8'h04:        return "R10";
      8'h10:        return "R4";
      8'h14:        return "R7";
      8'h18, 8'h1C: return "R8";
      default:      return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] wd,
                      input logic [31:0] rq, input logic [31:0] ob, input string tag);
    logic [31:0] clr;
    @(negedge clk);
    we = w; addr = a; wdata = wd; req = rq; obs_in = ob;
    #1;
    chk(tag == "" ? "R3" : tag, {21'h0, trig}, {21'h0, m_trig});
    chk(tag == "" ? "R6" : tag, {21'h0, obs_out}, {21'h0, gather(m_stat)});
    chk(tag == "" ? "R9" : tag, {31'h0, irq}, {31'h0, |(m_stat & ~m_mask)});
    chk(tag == "" ? rd_tag(a) : tag, rdata, exp_rd(a));
    clr = '0;
    m_trig = '0;
    if (w) begin
      case (a)
        8'h00: m_trig = gather(wd);
        8'h10: clr = wd & CM;
        8'h18: m_mask = m_mask & ~wd;
        8'h1C: m_mask = m_mask | (wd & CM);
        default: ;
      endcase
    end
    m_stat = (m_stat & ~clr) | (rq & CM);
    m_obs  = ob & CM;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_stat = '0; m_mask = CM; m_obs = '0; m_trig = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    step(0, 8'h14, 0, 0, 0, "R7");
    step(0, 8'h10, 0, 0, 0, "R4");
    // all-ones trigger: pulse on every channel, then gone
    step(1, 8'h00, 32'hFFFF_FFFF, 0, 0, "R1");
    step(0, 8'h00, 0, 0, 0, "R1");
    step(0, 8'h00, 0, 0, 0, "R3");
    // unmask all, then reserved-only mask strobe must not remask
    step(1, 8'h18, 32'hFFFF_FFFF, 0, 0, "R8");
    step(1, 8'h1C, 32'hF0F0_FCFE, 0, 0, "R1");
    step(0, 8'h14, 0, 0, 0, "R1");
    // direct mask write ignored
    step(1, 8'h14, 32'hFFFF_FFFF, 0, 0, "R7");
    step(0, 8'h14, 0, 0, 0, "R7");
    // set wins over clear
    step(0, 8'h10, 0, 32'h0000_0200, 0, "R5");
    step(1, 8'h10, 32'hFFFF_FFFF, 32'h0000_0200, 0, "R5");
    step(0, 8'h10, 0, 0, 0, "R5");
    // w1c clears; irq drops
    step(1, 8'h10, 32'h0000_0200, 0, 0, "R4");
    step(0, 8'h10, 0, 0, 0, "R9");
    // unmapped offset
    step(1, 8'h08, 32'hFFFF_FFFF, 0, 0, "R2");
    step(0, 8'h08, 0, 0, 0, "R2");
    step(0, 8'h0C, 0, 0, 0, "R2");
    // observation register
    step(0, 8'h04, 0, 0, 32'hFFFF_FFFF, "R10");
    step(1, 8'h04, 0, 0, 32'h0100_0001, "R10");
    step(0, 8'h04, 0, 0, 0, "R10");
    // remask all, pending status must not interrupt
    step(1, 8'h1C, 32'hFFFF_FFFF, 32'h0F00_0000, 0, "R8");
    step(0, 8'h10, 0, 0, 0, "R9");
    // random traffic
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] rq;
      rq = ($urandom % 6 == 0) ? $urandom : 32'h0;
      step($urandom % 2 == 0, {3'b0, 3'($urandom % 8), 2'b00}, $urandom, rq, $urandom, "");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule